// File: doc/BRIEF.md
# RTC Seconds Prescaler with Update-in-Progress Flag

This block divides the 32768 Hz timekeeping reference down to one update tick per second. The system clock runs faster than the reference. A single-cycle enable, `oscTick`, marks each reference period. A 15-bit phase counter (by default) advances on each enabled tick. When the counter wraps, the block emits a one-cycle end-of-update pulse. The calendar logic that sits next to this block uses that pulse to advance the time of day and to set its update-ended flag.

The block also owns the status/control byte that software reads as register A. Bit 7 of that byte is the read-only update-in-progress flag (UIP). UIP is high during the last `UIP_CYCLES` reference periods (8 by default, about 244 us) before every second boundary, so software can tell when a time-of-day read is unsafe. Bits 6:0 are ordinary software-written bits. Bits 6:4 are the divider-control code, and only the code 3'b010 lets time run. When the SET mode bit from register B is high, UIP is suppressed and no update pulse is produced, while the phase counter keeps running.

Top module: `rtc_presc_top`

## Requirements
- R1: After the synchronous active-high reset, `phase` is 0, `updateDone` is 0, and all eight bits of `regA` read 0, so the divider is halted.
- R2: While `regA[6:4]` equals 3'b010, `phase` rises by one on each clock edge where `oscTick` is 1. It wraps from 2^CNT_BITS-1 to 0 and holds when `oscTick` is 0.
- R3: `updateDone` is high for exactly one clock cycle, in the cycle right after the edge on which `phase` wraps to 0, provided `setMode` was 0 at that edge. It is low at all other times.
- R4: `regA[7]` (UIP) is 1 exactly when the divider is running, `setMode` was 0 at the last edge, and `phase` is one of the last UIP_CYCLES values (2^CNT_BITS-UIP_CYCLES through 2^CNT_BITS-1). Its falling edge at the wrap lands in the same cycle that `updateDone` rises.
- R5: While `setMode` is 1, UIP reads 0 from the next cycle onward and `updateDone` stays low. This clears a UIP that was already high. `phase` keeps counting.
- R6: A write (`ctrlWrEn` = 1) loads `ctrlWrData` into `regA[6:0]` on the next edge. It has no effect on the UIP bit or on `phase`.
- R7: While `regA[6:4]` is not 3'b010, `phase` is held at 0 from the next edge, and UIP and `updateDone` stay low. After the code returns to 3'b010, counting starts from 0 on the next enabled tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oscTick | input | 1 | One-cycle enable per reference period |
| ctrlWrEn | input | 1 | Register A write strobe |
| ctrlWrData | input | 7 | Value for the writable register A bits 6:0 |
| setMode | input | 1 | SET mode bit from register B |
| regA | output | 8 | Register A read value: bit 7 is UIP, bits 6:0 are the written bits |
| updateDone | output | 1 | One-cycle end-of-update pulse |
| phase | output | CNT_BITS | Prescaler phase readout |

## Verification
The bench builds the block with CNT_BITS = 6 and keeps UIP_CYCLES at 8. A second then lasts only 64 reference ticks, so several thousand cycles cover dozens of wraps. The UIP window still spans a full eighth of the second. This puts the window's rising and falling edges, SET raised inside the window, register A written inside the window, and halts and restarts around a wrap all within a short run. Random tick gaps, SET toggles and writes of both running and halting codes fill in the interleavings between these cases.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic run;      // divider code selects normal timekeeping
    logic advance;  // run and a reference tick this cycle
    logic quiet;    // SET mode: no UIP, no update pulse
  } prescStrobe_t;

  localparam logic [2:0] RUN_CODE = 3'b010;

endpackage

// File: rtl/rtc_presc_ctrl.sv
module rtc_presc_ctrl
  import rtc_presc_pkg::*;
#(
  parameter int CTRL_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 oscTick,
  input  logic                 ctrlWrEn,
  input  logic [CTRL_BITS-1:0] ctrlWrData,
  input  logic                 setMode,
  output logic [CTRL_BITS-1:0] ctrlBits,
  output prescStrobe_t         strobe
);

  localparam int CODE_HI = CTRL_BITS - 1;
  localparam int CODE_LO = CTRL_BITS - 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlBits <= '0;
    end else if (ctrlWrEn) begin
      ctrlBits <= ctrlWrData;
    end
  end

  logic runNow;
  assign runNow = (ctrlBits[CODE_HI:CODE_LO] == RUN_CODE);

  always_comb begin
    strobe.run     = runNow;
    strobe.advance = runNow & oscTick;
    strobe.quiet   = setMode;
  end

endmodule

// File: rtl/rtc_presc_dp.sv
module rtc_presc_dp
  import rtc_presc_pkg::*;
#(
  parameter int CNT_BITS   = 15,
  parameter int UIP_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  prescStrobe_t        strobe,
  output logic [CNT_BITS-1:0] phase,
  output logic                uipFlag,
  output logic                updateDone
);

  localparam logic [CNT_BITS-1:0] CNT_MAX     = {CNT_BITS{1'b1}};
  localparam int                  WIN_START_I = (1 << CNT_BITS) - UIP_CYCLES;
  localparam logic [CNT_BITS-1:0] WIN_START   = WIN_START_I[CNT_BITS-1:0];

  logic [CNT_BITS-1:0] phaseNext;
  logic                wrapNow;
  logic                inWindow;

  always_comb begin
    if (!strobe.run) begin
      phaseNext = '0;
    end else if (strobe.advance) begin
      phaseNext = phase + 1'b1;
    end else begin
      phaseNext = phase;
    end
  end

  assign wrapNow  = strobe.advance & (phase == CNT_MAX);
  assign inWindow = (phaseNext >= WIN_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      uipFlag    <= 1'b0;
      updateDone <= 1'b0;
    end else begin
      phase      <= phaseNext;
      uipFlag    <= strobe.run & ~strobe.quiet & inWindow;
      updateDone <= wrapNow & ~strobe.quiet;
    end
  end

endmodule

// File: rtl/rtc_presc_top.sv
module rtc_presc_top
  import rtc_presc_pkg::*;
#(
  parameter int CNT_BITS   = 15,
  parameter int UIP_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                oscTick,
  input  logic                ctrlWrEn,
  input  logic [6:0]          ctrlWrData,
  input  logic                setMode,
  output logic [7:0]          regA,
  output logic                updateDone,
  output logic [CNT_BITS-1:0] phase
);

  prescStrobe_t strobe;
  logic [6:0]   ctrlBits;
  logic         uipFlag;

  rtc_presc_ctrl #(.CTRL_BITS(7)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .oscTick   (oscTick),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .setMode   (setMode),
    .ctrlBits  (ctrlBits),
    .strobe    (strobe)
  );

  rtc_presc_dp #(.CNT_BITS(CNT_BITS), .UIP_CYCLES(UIP_CYCLES)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .phase     (phase),
    .uipFlag   (uipFlag),
    .updateDone(updateDone)
  );

  assign regA = {uipFlag, ctrlBits};

endmodule

// File: rtl/rtc_presc_chk.sv
module rtc_presc_chk #(
  parameter int CNT_BITS   = 15,
  parameter int UIP_CYCLES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                setMode,
  input logic [7:0]          regA,
  input logic                updateDone,
  input logic [CNT_BITS-1:0] phase
);

  localparam int                  WIN_START_I = (1 << CNT_BITS) - UIP_CYCLES;
  localparam logic [CNT_BITS-1:0] WIN_START   = WIN_START_I[CNT_BITS-1:0];

  logic       uip;
  logic [2:0] code;
  assign uip  = regA[7];
  assign code = regA[6:4];

  a_r4_uip_in_window: assert property (@(posedge clk) disable iff (rst)
    uip |-> (phase >= WIN_START));

  a_r4_fall_meets_update: assert property (@(posedge clk) disable iff (rst)
    ($fell(uip) && ($past(code) == 3'b010) && !$past(setMode)) |-> updateDone);

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    updateDone |=> !updateDone);

  a_r3_done_uip_low: assert property (@(posedge clk) disable iff (rst)
    updateDone |-> !uip);

  a_r5_set_silences: assert property (@(posedge clk) disable iff (rst)
    $past(setMode) |-> (!uip && !updateDone));

  a_r7_halt_holds_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(code) != 3'b010) |-> ((phase == '0) && !updateDone && !uip));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (($past(code) == 3'b010) && (phase != $past(phase)))
      |-> (phase == CNT_BITS'($past(phase) + 1'b1)));

endmodule

bind rtc_presc_top rtc_presc_chk #(.CNT_BITS(CNT_BITS), .UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .setMode   (setMode),
  .regA      (regA),
  .updateDone(updateDone),
  .phase     (phase)
);

// File: tb/rtc_presc_top_tb.sv
module rtc_presc_top_tb;

  localparam int CB   = 6;
  localparam int UW   = 8;
  localparam int PMAX = (1 << CB) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          oscTick = 1'b0;
  logic          ctrlWrEn = 1'b0;
  logic [6:0]    ctrlWrData = '0;
  logic          setMode = 1'b0;
  logic [7:0]    regA;
  logic          updateDone;
  logic [CB-1:0] phase;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  int         mPh = 0;
  bit         mUip = 1'b0;
  bit         mDone = 1'b0;
  logic [6:0] mCtrl = '0;

  always #4 clk = ~clk;

  rtc_presc_top #(.CNT_BITS(CB), .UIP_CYCLES(UW)) u_dut (
    .clk(clk), .rst(rst), .oscTick(oscTick), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .setMode(setMode), .regA(regA),
    .updateDone(updateDone), .phase(phase)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int modelPhase(logic [6:0] c, int ph, bit osc);
    if (c[6:4] != 3'b010) return 0;
    return osc ? ((ph + 1) & PMAX) : ph;
  endfunction

  function automatic bit modelUip(logic [6:0] c, int nph, bit st);
    return (c[6:4] == 3'b010) && !st && (nph >= PMAX + 1 - UW);
  endfunction

  // drive one cycle from a negedge, compare at the next negedge
  task automatic step(bit osc, bit st, bit wr, logic [6:0] wd);
    int nPh;
    oscTick = osc; setMode = st; ctrlWrEn = wr; ctrlWrData = wd;
    nPh   = modelPhase(mCtrl, mPh, osc);
    mUip  = modelUip(mCtrl, nPh, st);
    mDone = (mCtrl[6:4] == 3'b010) && osc && (mPh == PMAX) && !st;
    mPh   = nPh;
    if (wr) mCtrl = wd;
    @(posedge clk);
    @(negedge clk);
    chk("R2 phase", int'(phase), mPh);
    chk("R4 uip", int'(regA[7]), int'(mUip));
    chk("R3 updateDone", int'(updateDone), int'(mDone));
    chk("R6 ctrl bits", int'(regA[6:0]), int'(mCtrl));
  endtask

  task automatic runTo(int target);
    int guard = 0;
    while (mPh != target && guard < 1000) begin
      step(1'b1, 1'b0, 1'b0, 7'h0);
      guard++;
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 phase", int'(phase), 0);
    chk("R1 regA", int'(regA), 0);
    chk("R1 updateDone", int'(updateDone), 0);
    rst = 1'b0;

    // start running; the write edge itself still sees a halted code
    step(1'b1, 1'b0, 1'b1, 7'h20);
    chk("R7 phase after start write", int'(phase), 0);
    for (int i = 0; i < 2 * (PMAX + 1) + 10; i++) step(1'b1, 1'b0, 1'b0, 7'h0);

    // wrap: UIP falls exactly when the pulse rises
    runTo(PMAX);
    chk("R4 uip at last phase", int'(regA[7]), 1);
    step(1'b1, 1'b0, 1'b0, 7'h0);
    chk("R3 pulse at wrap", int'(updateDone), 1);
    chk("R4 uip low at wrap", int'(regA[7]), 0);
    step(1'b0, 1'b0, 1'b0, 7'h0);
    chk("R3 pulse one cycle", int'(updateDone), 0);

    // write inside the window keeps UIP
    runTo(PMAX - 3);
    step(1'b0, 1'b0, 1'b1, 7'h2A);
    chk("R6 uip kept on write", int'(regA[7]), 1);
    chk("R6 written bits", int'(regA[6:0]), 7'h2A);

    // SET raised inside the window
    runTo(PMAX - 5);
    step(1'b0, 1'b1, 1'b0, 7'h0);
    chk("R5 uip cleared by set", int'(regA[7]), 0);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b0, 7'h0);
      chk("R5 no pulse in set", int'(updateDone), 0);
    end
    chk("R5 phase keeps counting", int'(phase), 0);
    step(1'b0, 1'b0, 1'b0, 7'h0);

    // halt and resume
    step(1'b1, 1'b0, 1'b1, 7'h70);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 7'h0);
    chk("R7 halted phase", int'(phase), 0);
    step(1'b1, 1'b0, 1'b1, 7'h25);
    step(1'b1, 1'b0, 1'b0, 7'h0);
    chk("R7 restart from zero", int'(phase), 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit         osc = ($urandom % 4) != 0;
      bit         st  = setMode;
      bit         wr  = ($urandom % 64) == 0;
      logic [6:0] wd  = (($urandom % 4) == 0) ? 7'($urandom) : {3'b010, 4'($urandom)};
      if (($urandom % 40) == 0) st = !st;
      step(osc, st, wr, wd);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule